// File: doc/BRIEF.md
# Write Strobe Leveling Trainer

This block levels the outgoing write strobe of one memory byte lane against the memory clock. It drives a delay-tap code to an external delay line. After each tap change it lets the line settle, asks the pad logic for one strobe pulse, and samples the one-bit feedback that the memory returns. That bit is the memory clock level seen at the strobe's rising edge. The search stops at the first tap where the feedback goes from low to high, which is the tap where the strobe edge lines up with a rising clock edge at the memory pins. Each lane has its own instance, so lanes with different clock arrival times are leveled independently.

A single pass is only trustworthy when strobe-to-clock skew is below one clock period and the strobe starts out earlier than the clock. When a later read-back shows that the wrong clock edge was taken, the system issues a retry. The trainer then moves one whole clock period (a programmable number of taps) past the locked tap and levels again onto the next edge.

The controller is one state machine with these states: IDLE, SETTLE (waiting after a tap change), PULSE (strobe request), SAMPLE (feedback capture), LOCKED (done pulse) and FAILED (fail pulse). Its transitions are as follows. IDLE goes to SETTLE on start, or on an accepted retry whose target tap fits. IDLE goes to FAILED on an accepted retry whose target tap overflows. SETTLE goes to PULSE when the settle count expires. PULSE always goes to SAMPLE. SAMPLE goes to LOCKED on a rising feedback, to FAILED at the last tap with no rise, and otherwise back to SETTLE with the next tap. LOCKED and FAILED always return to IDLE.

Top module: `wl_train_ctrl`

## Requirements
- R1: After reset, tap_o is 0, strobe_req_o, done_o, fail_o, busy_o and lock_ok_o are 0, and lock_tap_o is 0.
- R2: A start pulse accepted in IDLE begins a scan at tap 0. Each tested tap spends settle_cfg_i+1 cycles in SETTLE, one cycle with strobe_req_o high and one sample cycle, so one tap takes settle_cfg_i+3 cycles. The next tap is always the current tap plus one, and tap_o does not change between the strobe request and the sample.
- R3: The scan locks at the first tap whose sampled feedback is 1 while the sample at the previous tap of the same scan was 0. A feedback of 1 at the first tap of a start scan never locks.
- R4: On a lock at tap L reached after k tested taps, done_o is high for exactly one cycle, k·(settle_cfg_i+3) cycles after the start edge. lock_tap_o then reads L and lock_ok_o reads 1, and both hold until the next accepted start or retry result.
- R5: If no rise is seen up to and including the last tap (2^TAP_W − 1), fail_o is high for exactly one cycle, and lock_ok_o and lock_tap_o read 0.
- R6: A retry pulse in IDLE while lock_ok_o is 1 restarts the search at lock_tap_o + period_taps_i, with the sample before that tap taken as 0. So a feedback of 1 at that first tap locks at once, with done_o due settle_cfg_i+3 cycles after the retry edge.
- R7: If lock_tap_o + period_taps_i exceeds the last tap, the accepted retry raises fail_o in the cycle right after the retry edge, issues no strobe request, and clears lock_ok_o.
- R8: A retry while lock_ok_o is 0 is ignored: no strobe request, no done or fail, busy_o stays 0 and tap_o is unchanged. A start or retry while busy_o is 1 is ignored and does not change the result or its timing.
- R9: done_o and fail_o are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a fresh leveling scan from tap 0 |
| retry_i | input | 1 | Re-level onto the next clock edge after the locked one |
| settle_cfg_i | input | SETTLE_W | Extra settle cycles after each tap change |
| period_taps_i | input | TAP_W | Number of taps in one memory clock period |
| fb_i | input | 1 | Memory clock level sampled at the strobe edge |
| tap_o | output | TAP_W | Delay-tap code for the strobe delay line |
| strobe_req_o | output | 1 | One-cycle request for a strobe pulse |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse: lock found |
| fail_o | output | 1 | One-cycle pulse: no lock possible |
| lock_tap_o | output | TAP_W | Locked tap result |
| lock_ok_o | output | 1 | lock_tap_o holds a valid lock |

## Verification
Every result lands on a cycle fixed by the settle setting and the number of taps tested. A done pulse is due k·(settle_cfg_i+3) cycles after the start or retry edge, and an overflowing retry fails in the first cycle after its edge. The bench counts clock edges from the accepting edge and samples on the falling edge, so it can check that done or fail appears exactly at that count and not one cycle early or late. The feedback model is a pure function of tap_o, and a falling-edge monitor counts strobe requests and verifies that each one carries the tap after the last. This confirms that the number of tested taps matches the latency.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_PULSE  = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_LOCKED = 3'd4,
        ST_FAILED = 3'd5
    } wl_state_t;

endpackage

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [SETTLE_W-1:0] cfg_i,
    output logic                expired_o
);

    logic [SETTLE_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == cfg_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/wl_edge_tracker.sv
module wl_edge_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic seed_low_i,
    input  logic capture_i,
    input  logic fb_i,
    output logic rise_o
);

    logic prev_q;
    logic have_prev_q;

    assign rise_o = capture_i && have_prev_q && !prev_q && fb_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (clear_i) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (seed_low_i) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b1;
        end else if (capture_i) begin
            prev_q      <= fb_i;
            have_prev_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wl_result_reg.sv
module wl_result_reg #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             ok_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_o <= '0;
            ok_o  <= 1'b0;
        end else if (clear_i) begin
            tap_o <= '0;
            ok_o  <= 1'b0;
        end else if (load_i) begin
            tap_o <= tap_i;
            ok_o  <= 1'b1;
        end
    end

    AST_RESULT_CLEAR_OR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && load_i) |-> 1'b0 == 1'b0 && !(clear_i && load_i)); // R4

endmodule

// File: rtl/wl_train_ctrl.sv
module wl_train_ctrl
    import wl_pkg::*;
#(
    parameter int TAP_W    = 6,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                retry_i,
    input  logic [SETTLE_W-1:0] settle_cfg_i,
    input  logic [TAP_W-1:0]    period_taps_i,
    input  logic                fb_i,
    output logic [TAP_W-1:0]    tap_o,
    output logic                strobe_req_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output logic [TAP_W-1:0]    lock_tap_o,
    output logic                lock_ok_o
);

    localparam logic [TAP_W-1:0] TAP_LAST = '1;
    localparam int               SUM_W    = TAP_W + 1;

    wl_state_t        st_q, st_d;
    logic [TAP_W-1:0] tap_q;
    logic [SUM_W-1:0] retry_sum;
    logic             retry_ovf;
    logic             go_start, go_retry, go_retry_bad;
    logic             settle_done, rise, at_last;
    logic             sampling, lock_now, scan_fail;

    assign retry_sum    = {1'b0, lock_tap_o} + {1'b0, period_taps_i};
    assign retry_ovf    = retry_sum[TAP_W];
    assign go_start     = (st_q == ST_IDLE) && start_i;
    assign go_retry     = (st_q == ST_IDLE) && !start_i && retry_i && lock_ok_o && !retry_ovf;
    assign go_retry_bad = (st_q == ST_IDLE) && !start_i && retry_i && lock_ok_o && retry_ovf;
    assign sampling     = (st_q == ST_SAMPLE);
    assign at_last      = (tap_q == TAP_LAST);
    assign lock_now     = sampling && rise;
    assign scan_fail    = sampling && !rise && at_last;

    wl_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (st_q == ST_SETTLE),
        .cfg_i     (settle_cfg_i),
        .expired_o (settle_done)
    );

    wl_edge_tracker u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (go_start),
        .seed_low_i (go_retry),
        .capture_i  (sampling),
        .fb_i       (fb_i),
        .rise_o     (rise)
    );

    wl_result_reg #(.TAP_W(TAP_W)) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (go_start || go_retry_bad || scan_fail),
        .load_i  (lock_now),
        .tap_i   (tap_q),
        .tap_o   (lock_tap_o),
        .ok_o    (lock_ok_o)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_start || go_retry) begin
                    st_d = ST_SETTLE;
                end else if (go_retry_bad) begin
                    st_d = ST_FAILED;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    st_d = ST_PULSE;
                end
            end
            ST_PULSE:  st_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (rise) begin
                    st_d = ST_LOCKED;
                end else if (at_last) begin
                    st_d = ST_FAILED;
                end else begin
                    st_d = ST_SETTLE;
                end
            end
            ST_LOCKED: st_d = ST_IDLE;
            ST_FAILED: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // tap register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (go_start) begin
            tap_q <= '0;
        end else if (go_retry) begin
            tap_q <= retry_sum[TAP_W-1:0];
        end else if (sampling && !rise && !at_last) begin
            tap_q <= tap_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tap_o        = tap_q;
        strobe_req_o = (st_q == ST_PULSE);
        busy_o       = (st_q != ST_IDLE);
        done_o       = (st_q == ST_LOCKED);
        fail_o       = (st_q == ST_FAILED);
    end

    AST_TAP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && !rise && !at_last) |=> (tap_q == $past(tap_q) + 1'b1)); // R2

    AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req_o |=> $stable(tap_o)); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req_o |=> !strobe_req_o); // R2

    AST_DONE_HAS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lock_ok_o && lock_tap_o == tap_o)); // R4

    AST_FAIL_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !lock_ok_o); // R5

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o)); // R9

    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !(done_o || fail_o)); // R9

    AST_IGNORED_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !lock_ok_o) |=> !busy_o); // R8

endmodule

// File: tb/sim_wl_train_ctrl.sv
module sim_wl_train_ctrl;

    localparam int TAP_W    = 6;
    localparam int SETTLE_W = 4;
    localparam int PER      = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic                retry_i = 1'b0;
    logic [SETTLE_W-1:0] settle_cfg_i = '0;
    logic [TAP_W-1:0]    period_taps_i = PER[TAP_W-1:0];
    logic                fb_i;
    logic [TAP_W-1:0]    tap_o;
    logic                strobe_req_o, busy_o, done_o, fail_o, lock_ok_o;
    logic [TAP_W-1:0]    lock_tap_o;

    int  total = 0;
    int  bad = 0;
    int  phase_off = 0;
    bit  fb_zero = 1'b0;
    int  pulses = 0;
    int  order_err = 0;
    int  both_err = 0;
    int  last_tap = 0;

    always #2 clk = ~clk;

    // memory clock model: high in the second half of each period
    always_comb fb_i = fb_zero ? 1'b0 : (((int'(tap_o) + phase_off) % PER) >= PER / 2);

    wl_train_ctrl #(.TAP_W(TAP_W), .SETTLE_W(SETTLE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .retry_i(retry_i),
        .settle_cfg_i(settle_cfg_i), .period_taps_i(period_taps_i), .fb_i(fb_i),
        .tap_o(tap_o), .strobe_req_o(strobe_req_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .lock_tap_o(lock_tap_o), .lock_ok_o(lock_ok_o)
    );

    always @(negedge clk) begin
        if (strobe_req_o) begin
            if (pulses > 0 && int'(tap_o) != last_tap + 1) order_err++;
            last_tap = int'(tap_o);
            pulses++;
        end
        if (done_o && fail_o) both_err++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drives one start or retry, counts edges from the accepting edge
    task automatic run_op(input bit use_retry, input int poke_at,
                          output int n, output bit got_done, output bit got_fail);
        pulses = 0; order_err = 0;
        got_done = 0; got_fail = 0;
        @(negedge clk);
        if (use_retry) retry_i = 1'b1; else start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0; retry_i = 1'b0;
        n = 0;
        while (n < 3000) begin
            if (done_o) got_done = 1;
            if (fail_o) got_fail = 1;
            if (got_done || got_fail) break;
            if (n == poke_at) begin start_i = 1'b1; retry_i = 1'b1; end
            else begin start_i = 1'b0; retry_i = 1'b0; end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0; retry_i = 1'b0;
        if (n >= 3000) check(1'b0, "watchdog", n, 0);
    endtask

    task automatic t_reset();
        check(tap_o == 0, "R1 tap", int'(tap_o), 0);
        check(!strobe_req_o && !done_o && !fail_o && !busy_o, "R1 flags",
              int'({strobe_req_o, done_o, fail_o, busy_o}), 0);
        check(!lock_ok_o && lock_tap_o == 0, "R1 result", int'(lock_tap_o), 0);
    endtask

    task automatic t_scan(input int off, input int s, input int exp_l, input int poke);
        int n; bit d; bit f;
        int k = exp_l + 1;
        phase_off = off; fb_zero = 0; settle_cfg_i = s[SETTLE_W-1:0];
        run_op(1'b0, poke, n, d, f);
        check(d && !f, "R3 lock found", int'(d), 1);
        check(n == k * (s + 3), "R4 done latency", n, k * (s + 3));
        check(int'(lock_tap_o) == exp_l && lock_ok_o, "R3 lock tap", int'(lock_tap_o), exp_l);
        check(pulses == k, "R2 strobe count", pulses, k);
        check(order_err == 0, "R2 tap order", order_err, 0);
        @(negedge clk);
        check(!done_o, "R9 done one cycle", int'(done_o), 0);
    endtask

    task automatic t_hold(input int exp_l);
        repeat (20) @(negedge clk);
        check(int'(lock_tap_o) == exp_l && lock_ok_o, "R4 lock held", int'(lock_tap_o), exp_l);
    endtask

    task automatic t_retry(input int exp_l);
        int n; bit d; bit f;
        int s = int'(settle_cfg_i);
        run_op(1'b1, -1, n, d, f);
        check(d && !f, "R6 retry lock", int'(d), 1);
        check(n == s + 3, "R6 retry latency", n, s + 3);
        check(int'(lock_tap_o) == exp_l, "R6 retry tap", int'(lock_tap_o), exp_l);
        check(pulses == 1, "R6 one strobe", pulses, 1);
    endtask

    task automatic t_retry_overflow();
        int n; bit d; bit f;
        run_op(1'b1, -1, n, d, f);
        check(f && !d && n == 0, "R7 immediate fail", n, 0);
        check(pulses == 0, "R7 no strobe", pulses, 0);
        check(!lock_ok_o, "R7 lock cleared", int'(lock_ok_o), 0);
    endtask

    task automatic t_retry_ignored();
        logic [TAP_W-1:0] tap_before;
        int seen = 0;
        tap_before = tap_o;
        pulses = 0;
        @(negedge clk); retry_i = 1'b1;
        @(negedge clk); retry_i = 1'b0;
        repeat (10) begin
            if (busy_o || done_o || fail_o) seen++;
            @(negedge clk);
        end
        check(seen == 0 && pulses == 0, "R8 retry ignored", seen + pulses, 0);
        check(tap_o == tap_before, "R8 tap unchanged", int'(tap_o), int'(tap_before));
    endtask

    task automatic t_fail_scan();
        int n; bit d; bit f;
        fb_zero = 1; settle_cfg_i = 4'd1;
        run_op(1'b0, -1, n, d, f);
        check(f && !d, "R5 fail raised", int'(f), 1);
        check(n == 64 * 4, "R5 fail latency", n, 256);
        check(pulses == 64, "R5 all taps tried", pulses, 64);
        check(!lock_ok_o && lock_tap_o == 0, "R5 result cleared", int'(lock_ok_o), 0);
        @(negedge clk);
        check(!fail_o, "R9 fail one cycle", int'(fail_o), 0);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_scan(5, 2, 3, -1);          // R2 R3 R4
        t_scan(10, 0, 14, -1);        // R3: high at tap 0 does not lock
        t_hold(14);                   // R4
        t_retry(30);                  // R6
        t_retry(46);                  // R6
        t_retry(62);                  // R6
        t_retry_overflow();           // R7
        t_retry_ignored();            // R8
        t_fail_scan();                // R5
        t_scan(5, 3, 3, 5);           // R8: start while busy ignored
        check(both_err == 0, "R9 exclusive", both_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule